// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable Word Gap

This block is a register-programmed SPI master. Software fills a transmit FIFO through a small word-addressed register port, programs the clock prescaler, word length, clock polarity and phase, a transfer word count and an inter-word gap, and then sets the transmit and/or receive enable bits. The engine shifts each word out MSB first on MOSI while it captures MISO into a receive FIFO. Between two words of a transfer it holds SCK idle for a programmed number of source-clock cycles.

Completion is reported through two raw status bits, transmit-done and receive-done. Each has an enable mask that gives a masked view, and a write-one-to-clear register clears it. A separate busy flag tells the driver when the final bit has really left the shifter. A receive-only mode generates clocks for a programmed number of words without transmit data. Four active-low chip selects are driven directly from control bits.

Register map (word addresses): 0 data (write pushes TX FIFO, read pops RX FIFO), 1 prescaler, 2 configuration, 3 count high part, 4 count low part, 5 gap select, 6 receive-only control, 7 status enable, 8 status clear, 9 raw status, 10 masked status, 11 engine status, 12 FIFO flush.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, all chip selects are high, SCK and MOSI are low, raw status reads 0 and engine status reads 0 (not busy, RX FIFO empty).
- R2: With prescaler value d (register 1), SCK toggles every d+1 source-clock cycles during a word, so one SCK period is 2×(d+1) cycles.
- R3: Configuration bit 5 selects the SCK idle level. With it set, SCK sits high whenever the engine is not busy.
- R4: Configuration bit 6 selects the phase. When it is 0, data is sampled on the leading edge and launched on the trailing edge. When it is 1, data is launched on the leading edge and sampled on the trailing edge. With MISO looped to MOSI, every word comes back unchanged in both phases.
- R5: Configuration bits 4:0 give the bits per word, with 0 meaning 32. Words go out MSB first, and a received word shorter than 32 bits is right-aligned in its RX FIFO entry.
- R6: With gap select g (register 5, bits 4:0) clamped to 1..30, SCK rests idle for 4g+10 cycles after a word's last edge. The next word's first edge therefore follows the last edge by 4g+10+d+1 cycles.
- R7: Writing the count low part (register 4, bits 15:0) loads a 20-bit word count whose upper 4 bits come from register 3. Exactly that many words are transferred, and raw status bit 8 (transmit-done) sets when the last word enters the shifter in transmit mode (configuration bit 13).
- R8: When transmit-done sets, engine status bit 0 (busy) is still 1. It falls once the last SCK edge of the final word has passed.
- R9: Raw status bit 9 (receive-done) sets when the final word is stored in receive mode (configuration bit 12). A transmit-only transfer sets only bit 8 and stores nothing.
- R10: Masked status equals raw status ANDed with register 7. Writing 1 to a bit of register 8 clears that raw bit, and writing 0 leaves it unchanged.
- R11: In receive-only mode, writing register 6 with bit 9 set and a 9-bit count in bits 8:0 clocks in that many words while MOSI stays low. Writing it with bit 9 clear cancels every word not yet started.
- R12: While register 12 bit 0 is 1 both FIFOs are emptied, so engine status bits 13:8 (RX level) read 0.
- R13: Chip-select outputs follow configuration bits 11:8 and change only on a configuration write.
- R14: With both mode bits clear the engine starts no word, and a count written in that state is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX FIFO at address 0) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that software does not change the polarity bit while a word is shifting, and that the engine is idle whenever receive mode is enabled and receive-done rises. They also assume that flushes are not issued while a receive word is being pushed. The bench respects all of this: it reprograms the configuration only after polling busy low, and it flushes only when the engine is idle. MISO is either looped from MOSI or held at a constant level, so every expected word follows directly from the data written.

// File: rtl/spi_gap_pkg.sv
`timescale 1ns/1ps
// Shared constants for the SPI gap master: register addresses, status bit
// positions, configuration field positions and engine states.
package spi_gap_pkg;
    localparam logic [3:0] ADR_DATA  = 4'd0;
    localparam logic [3:0] ADR_DIV   = 4'd1;
    localparam logic [3:0] ADR_CFG   = 4'd2;
    localparam logic [3:0] ADR_LENHI = 4'd3;
    localparam logic [3:0] ADR_LENLO = 4'd4;
    localparam logic [3:0] ADR_GAP   = 4'd5;
    localparam logic [3:0] ADR_RXO   = 4'd6;
    localparam logic [3:0] ADR_IEN   = 4'd7;
    localparam logic [3:0] ADR_ICLR  = 4'd8;
    localparam logic [3:0] ADR_RAW   = 4'd9;
    localparam logic [3:0] ADR_MSK   = 4'd10;
    localparam logic [3:0] ADR_STAT  = 4'd11;
    localparam logic [3:0] ADR_FLUSH = 4'd12;

    localparam int TXEND_BIT = 8;
    localparam int RXON_BIT  = 12;
    localparam int TXON_BIT  = 13;
    localparam int CPOL_BIT  = 5;
    localparam int CPHA_BIT  = 6;
    localparam int CS_LSB    = 8;

    localparam int GAP_SEL_MIN = 1;
    localparam int GAP_SEL_MAX = 30;
    localparam int GAP_BASE    = 10;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_state_e;
endpackage

// File: rtl/spi_gap_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with show-ahead output and a flush input.
// Assumes DEPTH is a power of two; pushes when full and pops when empty are dropped.
module spi_gap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [AW:0]   level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign do_push = push && (level != (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/spi_gap_shifter.sv
`timescale 1ns/1ps
// SPI shift engine: half-period timer, edge counter, MSB-first shifters,
// inter-word gap timer and remaining-word counter.
// Assumes cpol/cpha/wlen stay constant while busy is high.
module spi_gap_shifter
    import spi_gap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 20,
    parameter int GSEL_W = 5,
    localparam int LW    = $clog2(DATA_W),
    localparam int EW    = LW + 2,
    localparam int GCW   = GSEL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [LW-1:0]     wlen_i,
    input  logic [GSEL_W-1:0] gap_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              rem_ld_i,
    input  logic [CNT_W-1:0]  rem_val_i,
    input  logic              tx_empty_i,
    input  logic [DATA_W-1:0] tx_word_i,
    input  logic              miso_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              tx_last_o,
    output logic              rx_last_o,
    output logic              busy_o,
    output logic              sck_o,
    output logic              mosi_o
);
    eng_state_e        state;
    logic [DIV_W-1:0]  hc;
    logic [EW-1:0]     ec;
    logic [GCW-1:0]    gc, gcyc;
    logic [GSEL_W-1:0] gsel;
    logic [CNT_W-1:0]  rem;
    logic [DATA_W-1:0] shtx, shrx;
    logic [LW:0]       nbits, sh_amt;
    logic              lvl, mode_on, can_go, word_load, edge_ev, last_edge;
    logic              sample, shift_out, more;

    assign nbits   = (wlen_i == '0) ? (LW+1)'(DATA_W) : {1'b0, wlen_i};
    assign sh_amt  = (LW+1)'(DATA_W) - nbits;
    assign gsel    = (gap_i < GSEL_W'(GAP_SEL_MIN)) ? GSEL_W'(GAP_SEL_MIN) :
                     (gap_i > GSEL_W'(GAP_SEL_MAX)) ? GSEL_W'(GAP_SEL_MAX) : gap_i;
    assign gcyc    = GCW'({gsel, 2'b00}) + GCW'(GAP_BASE);
    assign mode_on = tx_en_i || rx_en_i;
    assign more    = (rem != '0) && mode_on;
    assign can_go  = more && (!tx_en_i || !tx_empty_i);
    assign word_load = can_go && ((state == ST_IDLE) ||
                       (state == ST_GAP && gc == gcyc - GCW'(1)));
    assign edge_ev   = (state == ST_SHIFT) && (hc == div_i);
    assign last_edge = edge_ev && (ec == {nbits, 1'b0} - EW'(1));
    assign sample    = edge_ev && (ec[0] == cpha_i);
    assign shift_out = edge_ev && !last_edge &&
                       (cpha_i ? (!ec[0] && ec != '0) : ec[0]);

    assign rx_word_o = sample ? {shrx[DATA_W-2:0], miso_i} : shrx;
    assign rx_push_o = last_edge && rx_en_i;
    assign rx_last_o = rx_push_o && (rem == '0);
    assign tx_pop_o  = word_load && tx_en_i;
    assign tx_last_o = tx_pop_o && (rem == CNT_W'(1));
    assign busy_o    = (state != ST_IDLE);
    assign sck_o     = lvl ^ cpol_i;
    assign mosi_o    = shtx[DATA_W-1];

    // Remaining-word counter: mode-off clear beats software load beats decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_on) rem <= '0;
        else if (rem_ld_i)      rem <= rem_val_i;
        else if (word_load)     rem <= rem - CNT_W'(1);
    end

    // Word sequencing, SCK timing and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hc    <= '0;
            ec    <= '0;
            gc    <= '0;
            lvl   <= 1'b0;
            shtx  <= '0;
            shrx  <= '0;
        end else if (word_load) begin
            state <= ST_SHIFT;
            hc    <= '0;
            ec    <= '0;
            shtx  <= tx_en_i ? (tx_word_i << sh_amt) : '0;
            shrx  <= '0;
        end else begin
            case (state)
                ST_SHIFT: begin
                    if (edge_ev) begin
                        hc  <= '0;
                        lvl <= ~lvl;
                        ec  <= ec + EW'(1);
                        if (sample)    shrx <= rx_word_o;
                        if (shift_out) shtx <= {shtx[DATA_W-2:0], 1'b0};
                        if (last_edge) begin
                            ec    <= '0;
                            gc    <= '0;
                            shtx  <= '0;
                            state <= more ? ST_GAP : ST_IDLE;
                        end
                    end else begin
                        hc <= hc + DIV_W'(1);
                    end
                end
                ST_GAP: begin
                    if (!more)                    state <= ST_IDLE;
                    else if (gc != gcyc - GCW'(1)) gc   <= gc + GCW'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_gap_master.sv
`timescale 1ns/1ps
// Top of the SPI gap master: register file, status bits, two FIFOs and the
// shift engine. Assumes software reconfigures only while busy is low.
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 20,
    parameter int RXO_W  = 9,
    parameter int NCS    = 4,
    parameter int GSEL_W = 5,
    localparam int LO_W  = 16,
    localparam int HI_W  = CNT_W - LO_W,
    localparam int LW    = $clog2(DATA_W),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [NCS-1:0] cs_n
);
    logic [DIV_W-1:0]  div_q;
    logic [LW-1:0]     wlen_q;
    logic              cpol_q, cpha_q, rxon_q, txon_q, flush_q;
    logic [NCS-1:0]    cs_q;
    logic [HI_W-1:0]   lenhi_q;
    logic [GSEL_W-1:0] gap_q;
    logic [1:0]        ien_q, raw_q;
    logic              cfg_wr, rem_ld, tx_pop, rx_push, tx_last, rx_last, eng_busy;
    logic [CNT_W-1:0]  rem_val;
    logic [DATA_W-1:0] tx_word, rx_word, rx_head;
    logic              tx_empty, rx_empty;
    logic [AW:0]       tx_level, rx_level;

    assign cfg_wr  = reg_wr && (reg_addr == ADR_CFG);
    assign rem_ld  = reg_wr && ((reg_addr == ADR_LENLO) || (reg_addr == ADR_RXO));
    assign rem_val = (reg_addr == ADR_LENLO) ? {lenhi_q, reg_wdata[LO_W-1:0]} :
                     reg_wdata[RXO_W] ? CNT_W'(reg_wdata[RXO_W-1:0]) : '0;
    assign cs_n    = cs_q;

    // Configuration registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0; wlen_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0;
            rxon_q <= 1'b0; txon_q <= 1'b0; cs_q <= '1; lenhi_q <= '0;
            gap_q <= '0; ien_q <= '0; flush_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_DIV:   div_q   <= reg_wdata[DIV_W-1:0];
                ADR_CFG: begin
                    wlen_q <= reg_wdata[LW-1:0];
                    cpol_q <= reg_wdata[CPOL_BIT];
                    cpha_q <= reg_wdata[CPHA_BIT];
                    cs_q   <= reg_wdata[CS_LSB +: NCS];
                    rxon_q <= reg_wdata[RXON_BIT];
                    txon_q <= reg_wdata[TXON_BIT];
                end
                ADR_LENHI: lenhi_q <= reg_wdata[HI_W-1:0];
                ADR_GAP:   gap_q   <= reg_wdata[GSEL_W-1:0];
                ADR_IEN:   ien_q   <= reg_wdata[TXEND_BIT +: 2];
                ADR_FLUSH: flush_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Raw done bits: set by the engine, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else begin
            for (int i = 0; i < 2; i++) begin
                if ((i == 0 && tx_last) || (i == 1 && rx_last)) raw_q[i] <= 1'b1;
                else if (reg_wr && reg_addr == ADR_ICLR && reg_wdata[TXEND_BIT+i])
                    raw_q[i] <= 1'b0;
            end
        end
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_DATA: reg_rdata = 32'(rx_head);
            ADR_DIV:  reg_rdata = 32'(div_q);
            ADR_RAW:  reg_rdata = 32'(raw_q) << TXEND_BIT;
            ADR_MSK:  reg_rdata = 32'(raw_q & ien_q) << TXEND_BIT;
            ADR_STAT: reg_rdata = (32'(rx_level) << 8) | 32'(eng_busy);
            default:  reg_rdata = '0;
        endcase
    end

    spi_gap_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(reg_wr && reg_addr == ADR_DATA), .din(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .dout(tx_word), .empty(tx_empty), .level(tx_level));

    spi_gap_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(rx_push), .din(rx_word),
        .pop(reg_rd && reg_addr == ADR_DATA), .dout(rx_head),
        .empty(rx_empty), .level(rx_level));

    spi_gap_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .GSEL_W(GSEL_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .div_i(div_q), .wlen_i(wlen_q), .gap_i(gap_q),
        .cpol_i(cpol_q), .cpha_i(cpha_q), .tx_en_i(txon_q), .rx_en_i(rxon_q),
        .rem_ld_i(rem_ld), .rem_val_i(rem_val), .tx_empty_i(tx_empty),
        .tx_word_i(tx_word), .miso_i(miso), .tx_pop_o(tx_pop), .rx_push_o(rx_push),
        .rx_word_o(rx_word), .tx_last_o(tx_last), .rx_last_o(rx_last),
        .busy_o(eng_busy), .sck_o(sck), .mosi_o(mosi));
endmodule

// File: rtl/spi_gap_checker.sv
`timescale 1ns/1ps
// Property checker for the SPI gap master, attached by bind.
module spi_gap_checker #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sck,
    input logic [NCS-1:0] cs_n,
    input logic           busy,
    input logic           cpol,
    input logic           raw_tx,
    input logic           raw_rx,
    input logic           rx_en,
    input logic           cfg_wr,
    input logic           flush,
    input logic           rx_empty
);
    // R3: an idle engine holds SCK at the polarity level.
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);

    // R2: SCK moves (polarity unchanged) only while a word is in flight.
    a_r2_sck_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && $stable(cpol)) |-> $past(busy));

    // R8: transmit-done rises while the shifter is still busy.
    a_r8_busy_after_txend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_tx) |-> busy);

    // R9: receive-done rises only in receive mode.
    a_r9_rxend_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_rx) |-> $past(rx_en));

    // R12: a flush leaves the receive FIFO empty.
    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> rx_empty);

    // R13: chip selects change only after a configuration write.
    a_r13_cs_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> $past(cfg_wr));
endmodule

bind spi_gap_master spi_gap_checker #(.NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .busy(eng_busy),
    .cpol(cpol_q), .raw_tx(raw_q[0]), .raw_rx(raw_q[1]), .rx_en(rxon_q),
    .cfg_wr(cfg_wr), .flush(flush_q), .rx_empty(rx_empty));

// File: tb/spi_gap_master_test.sv
`timescale 1ns/1ps
// Scoreboard bench: push tasks queue expected words, drain task pops and compares.
module spi_gap_master_test;
    import spi_gap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n, reg_wr, reg_rd, miso;
    logic [3:0]  reg_addr, cs_n;
    logic [31:0] reg_wdata, reg_rdata;
    logic        sck, mosi;
    logic        loop_on = 1'b1, miso_const = 1'b0;
    int          errs = 0, checks = 0, cyc = 0;
    int          tog_cnt, min_d, max_d, last_t;
    logic        mosi_hi, sck_prev = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] d;

    always #2.5 clk = ~clk;
    assign miso = loop_on ? mosi : miso_const;

    spi_gap_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    // SCK edge timing and MOSI activity monitor, sampled on falling clock.
    always @(negedge clk) begin
        cyc++;
        if (sck !== sck_prev) begin
            if (tog_cnt > 0) begin
                if (cyc - last_t < min_d) min_d = cyc - last_t;
                if (cyc - last_t > max_d) max_d = cyc - last_t;
            end
            tog_cnt++;
            last_t = cyc;
        end
        sck_prev = sck;
        if (mosi === 1'b1) mosi_hi = 1'b1;
    end

    task automatic win_reset();
        tog_cnt = 0; min_d = 1000000; max_d = 0; mosi_hi = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic push(input logic [31:0] w, input int n);
        wr(ADR_DATA, w);
        exp_q.push_back(n == 32 ? w : (w & ((32'd1 << n) - 1)));
    endtask

    task automatic drain(input string req);
        logic [31:0] v, e;
        while (exp_q.size() > 0) begin
            rd(ADR_DATA, v);
            e = exp_q.pop_front();
            chk(req, v, e);
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 5000; i++) begin
            rd(ADR_STAT, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    function automatic logic [31:0] cfgw(input int wl, input bit pol, input bit pha,
                                         input logic [3:0] cs, input bit rx, input bit tx);
        return 32'(wl) | (32'(pol) << CPOL_BIT) | (32'(pha) << CPHA_BIT) |
               (32'(cs) << CS_LSB) | (32'(rx) << RXON_BIT) | (32'(tx) << TXON_BIT);
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        win_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", 32'(cs_n), 32'hF);
        chk("R1 sck", 32'(sck), 0);
        chk("R1 mosi", 32'(mosi), 0);
        rd(ADR_RAW, d);  chk("R1 raw", d, 0);
        rd(ADR_STAT, d); chk("R1 stat", d, 0);

        // R13: chip selects follow configuration
        wr(ADR_CFG, cfgw(8, 0, 0, 4'b1110, 0, 0));
        @(negedge clk); chk("R13 cs_n", 32'(cs_n), 32'hE);

        // Mode 0, 8-bit words, prescaler 2, gap select 3
        wr(ADR_DIV, 2); wr(ADR_GAP, 3);
        wr(ADR_CFG, cfgw(8, 0, 0, 4'b1110, 1, 1));
        push(32'hA5, 8); push(32'h3C, 8); push(32'h1F0, 8);
        wr(ADR_LENHI, 0); win_reset();
        wr(ADR_LENLO, 3);
        for (int i = 0; i < 5000; i++) begin
            rd(ADR_RAW, d);
            if (d[8]) break;
        end
        rd(ADR_STAT, d); chk("R8 busy at tx-done", 32'(d[0]), 1);
        wait_idle();
        rd(ADR_STAT, d); chk("R8 busy falls", 32'(d[0]), 0);
        chk("R2 half period", 32'(min_d), 3);
        chk("R6 gap 4*3+10+3", 32'(max_d), 25);
        chk("R7 edge count", 32'(tog_cnt), 48);
        rd(ADR_RAW, d); chk("R7 R9 raw both", d, 32'h300);
        drain("R4 R5 mode0 loopback");

        // R10: masking and write-one-to-clear
        wr(ADR_IEN, 32'h100);
        rd(ADR_MSK, d); chk("R10 masked", d, 32'h100);
        wr(ADR_ICLR, 0);
        rd(ADR_RAW, d); chk("R10 clear zero", d, 32'h300);
        wr(ADR_ICLR, 32'h100);
        rd(ADR_RAW, d); chk("R10 clear tx", d, 32'h200);
        wr(ADR_ICLR, 32'h200);
        rd(ADR_RAW, d); chk("R10 clear rx", d, 0);

        // R3/R4: polarity 1, phase 1, 12-bit words
        wr(ADR_CFG, cfgw(12, 1, 1, 4'b1110, 1, 1));
        @(negedge clk); chk("R3 idle high", 32'(sck), 1);
        push(32'hABC, 12); push(32'h123, 12);
        wr(ADR_LENLO, 2); wait_idle();
        drain("R4 mode3 loopback");

        // R5: length field 0 means 32 bits, phase 1
        wr(ADR_CFG, cfgw(0, 0, 1, 4'b1110, 1, 1));
        push(32'hDEADBEEF, 32);
        wr(ADR_LENLO, 1); wait_idle();
        drain("R5 32-bit word");

        // R6: gap select clamping, prescaler 0, 4-bit words
        wr(ADR_DIV, 0); wr(ADR_GAP, 0);
        wr(ADR_CFG, cfgw(4, 0, 0, 4'b1110, 1, 1));
        push(32'h5, 4); push(32'hA, 4);
        win_reset(); wr(ADR_LENLO, 2); wait_idle();
        chk("R6 low clamp", 32'(max_d), 15);
        drain("R6 data");
        wr(ADR_GAP, 31);
        push(32'h9, 4); push(32'h6, 4);
        win_reset(); wr(ADR_LENLO, 2); wait_idle();
        chk("R6 high clamp", 32'(max_d), 131);
        drain("R6 data");

        // R9: transmit-only sets only bit 8 and stores nothing
        wr(ADR_ICLR, 32'h300);
        wr(ADR_CFG, cfgw(8, 0, 0, 4'b1110, 0, 1));
        wr(ADR_DATA, 32'h11); wr(ADR_DATA, 32'h22);
        wr(ADR_LENLO, 2); wait_idle();
        rd(ADR_RAW, d);  chk("R9 tx only raw", d, 32'h100);
        rd(ADR_STAT, d); chk("R9 tx only rx level", d, 0);

        // R11: receive-only with MISO high
        wr(ADR_ICLR, 32'h300);
        loop_on = 1'b0; miso_const = 1'b1;
        wr(ADR_CFG, cfgw(9, 0, 0, 4'b1110, 1, 0));
        win_reset();
        wr(ADR_RXO, 32'h200 | 3); wait_idle();
        chk("R11 mosi low", 32'(mosi_hi), 0);
        rd(ADR_STAT, d); chk("R11 three words", d, 32'h300);
        rd(ADR_RAW, d);  chk("R11 rx-done only", d, 32'h200);
        repeat (3) exp_q.push_back(32'h1FF);
        drain("R11 receive data");
        wr(ADR_RXO, 32'h200 | 5); wr(ADR_RXO, 0); wait_idle();
        rd(ADR_STAT, d); chk("R11 cancel keeps one", d, 32'h100);

        // R12: flush empties the receive FIFO
        wr(ADR_FLUSH, 1); wr(ADR_FLUSH, 0);
        rd(ADR_STAT, d); chk("R12 flushed", d, 0);

        // R14: count written with modes off is discarded
        loop_on = 1'b1;
        wr(ADR_CFG, cfgw(8, 0, 0, 4'b1110, 0, 0));
        wr(ADR_DATA, 32'h77);
        wr(ADR_LENLO, 1);
        win_reset();
        wr(ADR_CFG, cfgw(8, 0, 0, 4'b1110, 0, 1));
        repeat (30) @(negedge clk);
        rd(ADR_STAT, d); chk("R14 stays idle", d, 0);
        chk("R14 no sck", 32'(tog_cnt), 0);
        wr(ADR_FLUSH, 1); wr(ADR_FLUSH, 0);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule